// File: doc/BRIEF.md
# Flash Program-Verify Pulse Engine

This block writes one or more flash words into an array through a repeated pulse and verify loop. Each flash word holds 128 data bits plus a 16-bit ECC field, so it is 144 bits wide. Before an operation, the data registers are loaded with the target pattern through a write port. A 0 bit means "program this cell" and a 1 bit means "leave erased". During the operation the same registers act as a live mask. After every verify read, each enabled bit that the array now reads as 0 is set to 1 in its register. The mask therefore shrinks until the word is complete.

An operation starts with a base address, a size code and a byte-enable mask. The sequencer visits the selected words in order and verifies each one before its first pulse. While enabled mask bits remain, it issues a pulse carrying those bits and then verifies again. The per-word pulse counter restarts for every word. A word that still has open mask bits after `MAX_PULSES` pulses ends the operation with a verify-failure status. The array is reached through a plain address, pulse strobe, pulse mask and read-data interface.

Top module: `flpv_engine`

## Requirements
- R1: `size_code` s selects 2**s words (s = 0..3). Word k is processed only at `arr_addr` = `base_addr` + k, in increasing address order, and no earlier word is revisited.
- R2: `byte_en` bit j (j = 0..15) enables data bits 8j..8j+7, and bit 16 enables the ECC bits 128..143. A disabled bit never appears in `arr_pmask`, so the array cell behind it is left unchanged.
- R3: While `arr_pulse` is high, `arr_pmask` has a 1 exactly at the enabled bits whose data register bit is still 0. No pulse is issued while that set is empty.
- R4: After each verify, every enabled bit that reads 0 on `arr_rdata` has its data register bit set to 1. Disabled bits, and words outside the operation or after a failing word, keep their written value, as seen on `rd_data` for `rd_idx`.
- R5: A word receives at most `MAX_PULSES` (default 6) pulses, and the count restarts for each word. If its mask is still not empty after the last permitted pulse and verify, the operation ends with `fail_verify`=1 and `pass`=0, and later words receive no pulse.
- R6: When every selected word reaches an empty mask, the operation ends with `pass`=1 and `fail_verify`=0.
- R7: `done` is high for exactly one cycle, in the cycle `busy` falls. `pass` and `fail_verify` hold their values until the next accepted start, which clears them.
- R8: `start` and `wr_en` are ignored while `busy` is high.
- R9: After reset, `busy`, `done`, `pass` and `fail_verify` are 0 and every data register reads all ones.
- R10: Each word is verified before its first pulse. A word whose enabled target bits already read 0 completes with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| size_code | input | 2 | Word count code, 2**size_code words |
| base_addr | input | 16 | Word address of the first word |
| byte_en | input | 17 | Byte enables; bit 16 covers the ECC field |
| wr_en | input | 1 | Load a data register |
| wr_idx | input | 3 | Data register index to load |
| wr_data | input | 144 | Target pattern, 0 = program |
| rd_idx | input | 3 | Data register index to read back |
| rd_data | output | 144 | Current contents of the selected data register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| pass | output | 1 | Last operation completed every word |
| fail_verify | output | 1 | Last operation hit the pulse limit |
| arr_addr | output | 16 | Array word address |
| arr_pulse | output | 1 | Program pulse strobe |
| arr_pmask | output | 144 | Bits to program during the pulse |
| arr_rdata | input | 144 | Array read data at `arr_addr` |

## Verification
A mask bit that is not cleared after a verify appears in the pulse mask of the next pulse. It inflates the pulse count of that word and, when pushed past the limit, turns a pass into a verify failure within that word's seven verify rounds. A word index or counter that steps wrongly shows up as pulses landing at the wrong array address, or as a word that is skipped and keeps its loaded pattern on readback. A stuck status flag shows up on the first `done` strobe after it goes wrong.

// File: rtl/flpv_pkg.sv
package flpv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_VERIFY = 2'd1,
      ST_CHECK  = 2'd2,
      ST_PULSE  = 2'd3
   } flpv_state_e;

endpackage

// File: rtl/flpv_mask_bank.sv
// Data registers that double as the live program mask.
module flpv_mask_bank #(
   parameter int WORD_BITS = 144,
   parameter int MAX_WORDS = 8,
   localparam int IDX_W    = $clog2(MAX_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [WORD_BITS-1:0] wr_data,
   input  logic                 wr_block,
   input  logic                 upd_en,
   input  logic [IDX_W-1:0]     cur_idx,
   input  logic [WORD_BITS-1:0] arr_rdata,
   input  logic [WORD_BITS-1:0] bit_en,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [WORD_BITS-1:0] rd_data,
   output logic [WORD_BITS-1:0] active
);

   logic [WORD_BITS-1:0] regs_w [MAX_WORDS];

   for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
      logic [WORD_BITS-1:0] q;
      logic                 sel_cur;
      logic                 sel_wr;

      assign sel_cur = (cur_idx == IDX_W'(w));
      assign sel_wr  = (wr_idx  == IDX_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '1;
         end else if (upd_en && sel_cur) begin
            // enabled bits that now read programmed leave the mask
            q <= q | (~arr_rdata & bit_en);
         end else if (wr_en && !wr_block && sel_wr) begin
            q <= wr_data;
         end
      end

      assign regs_w[w] = q;
   end

   assign rd_data = regs_w[rd_idx];
   assign active  = ~regs_w[cur_idx] & bit_en;

endmodule

// File: rtl/flpv_seq.sv
// Word sequencer, pulse/verify loop and per-word pulse counter.
module flpv_seq
   import flpv_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int IDX_W      = 3,
   parameter int SIZE_W     = 2,
   parameter int BE_W       = 17,
   parameter int MAX_PULSES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SIZE_W-1:0] size_code,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [BE_W-1:0]   byte_en,
   input  logic              mask_empty,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail_verify,
   output logic [IDX_W-1:0]  word_idx,
   output logic [ADDR_W-1:0] arr_addr,
   output logic              upd_en,
   output logic              arr_pulse,
   output logic [BE_W-1:0]   be_q
);

   localparam int CNT_W = $clog2(MAX_PULSES + 1);
   localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_PULSES);

   flpv_state_e       state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] base_q;
   logic              done_q;
   logic              pass_q;
   logic              fail_q;
   logic [IDX_W:0]    words_sh;
   logic [IDX_W-1:0]  last_d;

   always_comb begin
      words_sh = {{IDX_W{1'b0}}, 1'b1} << size_code;
      last_d   = IDX_W'(words_sh - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         last_q  <= '0;
         cnt_q   <= '0;
         base_q  <= '0;
         be_q    <= '0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  base_q  <= base_addr;
                  be_q    <= byte_en;
                  last_q  <= last_d;
                  idx_q   <= '0;
                  cnt_q   <= '0;
                  pass_q  <= 1'b0;
                  fail_q  <= 1'b0;
                  state_q <= ST_VERIFY;
               end
            end
            ST_VERIFY: state_q <= ST_CHECK;
            ST_CHECK: begin
               if (mask_empty) begin
                  if (idx_q == last_q) begin
                     done_q  <= 1'b1;
                     pass_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     cnt_q   <= '0;
                     state_q <= ST_VERIFY;
                  end
               end else if (cnt_q == CNT_LIMIT) begin
                  done_q  <= 1'b1;
                  fail_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_PULSE;
               end
            end
            ST_PULSE: begin
               cnt_q   <= cnt_q + 1'b1;
               state_q <= ST_VERIFY;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign pass        = pass_q;
   assign fail_verify = fail_q;
   assign word_idx    = idx_q;
   assign arr_addr    = base_q + ADDR_W'(idx_q);
   assign upd_en      = (state_q == ST_VERIFY);
   assign arr_pulse   = (state_q == ST_PULSE);

endmodule

// File: rtl/flpv_engine.sv
module flpv_engine #(
   parameter int DATA_BYTES  = 16,
   parameter int HAS_ECC     = 1,
   parameter int ECC_BITS    = 16,
   parameter int MAX_WORDS   = 8,
   parameter int ADDR_W      = 16,
   parameter int MAX_PULSES  = 6,
   localparam int DATA_BITS  = DATA_BYTES * 8,
   localparam int WORD_BITS  = DATA_BITS + ((HAS_ECC != 0) ? ECC_BITS : 0),
   localparam int BE_W       = DATA_BYTES + ((HAS_ECC != 0) ? 1 : 0),
   localparam int IDX_W      = $clog2(MAX_WORDS),
   localparam int SIZE_W     = $clog2(IDX_W + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [SIZE_W-1:0]    size_code,
   input  logic [ADDR_W-1:0]    base_addr,
   input  logic [BE_W-1:0]      byte_en,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [WORD_BITS-1:0] wr_data,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [WORD_BITS-1:0] rd_data,
   output logic                 busy,
   output logic                 done,
   output logic                 pass,
   output logic                 fail_verify,
   output logic [ADDR_W-1:0]    arr_addr,
   output logic                 arr_pulse,
   output logic [WORD_BITS-1:0] arr_pmask,
   input  logic [WORD_BITS-1:0] arr_rdata
);

   if (MAX_WORDS < 2 || (MAX_WORDS & (MAX_WORDS - 1)) != 0) begin : g_bad_words
      $error("flpv_engine: MAX_WORDS must be a power of two, at least 2");
   end
   if (MAX_PULSES < 1) begin : g_bad_pulses
      $error("flpv_engine: MAX_PULSES must be at least 1");
   end
   if (HAS_ECC != 0 && ECC_BITS < 1) begin : g_bad_ecc
      $error("flpv_engine: ECC_BITS must be positive when HAS_ECC is set");
   end

   logic [BE_W-1:0]      be_q;
   logic [WORD_BITS-1:0] bit_en;
   logic [WORD_BITS-1:0] active;
   logic [IDX_W-1:0]     word_idx;
   logic                 upd_en;
   logic                 mask_empty;

   // byte enables fanned out to bit enables
   for (genvar b = 0; b < DATA_BITS; b++) begin : g_den
      assign bit_en[b] = be_q[b / 8];
   end
   if (HAS_ECC != 0) begin : g_ecc
      for (genvar e = 0; e < ECC_BITS; e++) begin : g_een
         assign bit_en[DATA_BITS + e] = be_q[DATA_BYTES];
      end
   end

   assign mask_empty = ~|active;
   assign arr_pmask  = arr_pulse ? active : '0;

   flpv_seq #(
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .SIZE_W     (SIZE_W),
      .BE_W       (BE_W),
      .MAX_PULSES (MAX_PULSES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .size_code   (size_code),
      .base_addr   (base_addr),
      .byte_en     (byte_en),
      .mask_empty  (mask_empty),
      .busy        (busy),
      .done        (done),
      .pass        (pass),
      .fail_verify (fail_verify),
      .word_idx    (word_idx),
      .arr_addr    (arr_addr),
      .upd_en      (upd_en),
      .arr_pulse   (arr_pulse),
      .be_q        (be_q)
   );

   flpv_mask_bank #(
      .WORD_BITS (WORD_BITS),
      .MAX_WORDS (MAX_WORDS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .wr_block  (busy),
      .upd_en    (upd_en),
      .cur_idx   (word_idx),
      .arr_rdata (arr_rdata),
      .bit_en    (bit_en),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .active    (active)
   );

endmodule

// File: rtl/flpv_engine_chk.sv
module flpv_engine_chk #(
   parameter int ADDR_W     = 16,
   parameter int WORD_BITS  = 144,
   parameter int MAX_PULSES = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 done,
   input logic                 pass,
   input logic                 fail_verify,
   input logic                 arr_pulse,
   input logic [WORD_BITS-1:0] arr_pmask,
   input logic [WORD_BITS-1:0] bit_en,
   input logic [ADDR_W-1:0]    arr_addr
);

   logic [31:0]       pc_q;
   logic [ADDR_W-1:0] prev_addr_q;

   // pulses seen at the current word address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q        <= '0;
         prev_addr_q <= '0;
      end else begin
         prev_addr_q <= arr_addr;
         if (!busy || arr_addr != prev_addr_q) pc_q <= '0;
         else if (arr_pulse)                   pc_q <= pc_q + 1'b1;
      end
   end

   p_pmask_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arr_pulse |-> ((arr_pmask & ~bit_en) == '0));

   p_pulse_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      arr_pulse |-> (arr_pmask != '0));

   p_pulse_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q <= 32'(MAX_PULSES));

   p_done_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass != fail_verify));

   p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind flpv_engine flpv_engine_chk #(
   .ADDR_W     (ADDR_W),
   .WORD_BITS  (WORD_BITS),
   .MAX_PULSES (MAX_PULSES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .pass        (pass),
   .fail_verify (fail_verify),
   .arr_pulse   (arr_pulse),
   .arr_pmask   (arr_pmask),
   .bit_en      (bit_en),
   .arr_addr    (arr_addr)
);

// File: tb/tb_flpv_engine.sv
module tb_flpv_engine;

   localparam int WB   = 144;
   localparam int BEW  = 17;
   localparam int IDXW = 3;
   localparam int AW   = 16;
   localparam int MAXP = 6;
   localparam int NARR = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic           start = 1'b0;
   logic [1:0]     size_code = '0;
   logic [AW-1:0]  base_addr = '0;
   logic [BEW-1:0] byte_en = '0;
   logic           wr_en = 1'b0;
   logic [IDXW-1:0] wr_idx = '0;
   logic [WB-1:0]  wr_data = '0;
   logic [IDXW-1:0] rd_idx = '0;
   logic [WB-1:0]  rd_data;
   logic           busy, done, pass, fail_verify;
   logic [AW-1:0]  arr_addr;
   logic           arr_pulse;
   logic [WB-1:0]  arr_pmask;
   logic [WB-1:0]  arr_rdata;

   flpv_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
      .base_addr(base_addr), .byte_en(byte_en), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
      .rd_data(rd_data), .busy(busy), .done(done), .pass(pass),
      .fail_verify(fail_verify), .arr_addr(arr_addr),
      .arr_pulse(arr_pulse), .arr_pmask(arr_pmask), .arr_rdata(arr_rdata)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [WB-1:0]  data_w [8];
   logic [WB-1:0]  arr_mem [NARR];
   int             arr_pc [NARR];
   int             salt = 0, span = 1, hard_on = 0, hard_a = 0, hard_b = 0;
   int             base_cur = 0, preset_all = 0;
   logic [BEW-1:0] be_cur = '0;
   int             pmask_bad = 0, order_bad = 0;
   bit             pulse_seen = 1'b0;
   logic [AW-1:0]  last_pa = '0;
   logic           arr_reset = 1'b0;

   assign arr_rdata = arr_mem[arr_addr[4:0]];

   function automatic int need_of(int a, int b);
      int n;
      n = 1 + ((a * 37 + b * 11 + salt) % span);
      if (hard_on != 0 && a == hard_a && b == hard_b) n = MAXP + 1;
      return n;
   endfunction

   function automatic logic [WB-1:0] preset_of(int a);
      logic [WB-1:0] r;
      if (preset_all != 0 && a >= base_cur && a < base_cur + 8)
         return ~data_w[a - base_cur];
      for (int b = 0; b < WB; b++) r[b] = (((a * 5 + b * 3 + salt) % 29) == 0);
      return r;
   endfunction

   function automatic logic [WB-1:0] ben_of(logic [BEW-1:0] be);
      logic [WB-1:0] r;
      for (int b = 0; b < 128; b++) r[b] = be[b / 8];
      for (int b = 128; b < WB; b++) r[b] = be[16];
      return r;
   endfunction

   function automatic logic [WB-1:0] rand_word();
      logic [159:0] t1, t2;
      t1 = {$urandom, $urandom, $urandom, $urandom, $urandom};
      t2 = {$urandom, $urandom, $urandom, $urandom, $urandom};
      return ~(t1[WB-1:0] & t2[WB-1:0]);
   endfunction

   // array model: a bit programs once its pulse count reaches its need
   always @(posedge clk) begin
      if (arr_reset) begin
         for (int a = 0; a < NARR; a++) begin
            arr_mem[a] <= ~preset_of(a);
            arr_pc[a]  <= 0;
         end
         pmask_bad  <= 0;
         order_bad  <= 0;
         pulse_seen <= 1'b0;
      end else if (arr_pulse) begin
         if ((arr_pmask & ~ben_of(be_cur)) != '0) pmask_bad <= pmask_bad + 1;
         if (pulse_seen && arr_addr < last_pa) order_bad <= order_bad + 1;
         pulse_seen <= 1'b1;
         last_pa    <= arr_addr;
         arr_pc[arr_addr[4:0]] <= arr_pc[arr_addr[4:0]] + 1;
         for (int b = 0; b < WB; b++)
            if (arr_pmask[b] && need_of(int'(arr_addr[4:0]), b) <= arr_pc[arr_addr[4:0]] + 1)
               arr_mem[arr_addr[4:0]][b] <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [WB-1:0] act, input logic [WB-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input int size, input int base, input logic [BEW-1:0] be,
                         input bit inject);
      int n, maxn, pl, ne, a, stop, total;
      bit got, exp_pass, r_pass, r_fail;
      logic [WB-1:0] active, exp_d, exp_a, init;
      n = 1 << size;
      base_cur = base;
      be_cur   = be;
      @(negedge clk) arr_reset = 1'b1;
      @(negedge clk) arr_reset = 1'b0;
      for (int w = 0; w < 8; w++) begin
         wr_en = 1'b1; wr_idx = IDXW'(w); wr_data = data_w[w];
         @(negedge clk);
      end
      wr_en = 1'b0;
      start = 1'b1; size_code = 2'(size); base_addr = AW'(base); byte_en = be;
      @(negedge clk);
      start = 1'b0;
      if (inject) begin
         wr_en = 1'b1; wr_idx = '0; wr_data = ~data_w[0];
         start = 1'b1; base_addr = AW'(base + 3); byte_en = '0; size_code = '0;
         @(negedge clk);
         wr_en = 1'b0; start = 1'b0;
      end
      got = 1'b0;
      for (int t = 0; t < 3000; t++) begin
         if (done) begin got = 1'b1; break; end
         @(negedge clk);
      end
      chk(got, "R7", "done strobe seen", WB'(got), WB'(1));
      if (!got) return;
      r_pass = pass; r_fail = fail_verify;
      @(negedge clk);
      chk(!done && !busy && pass == r_pass && fail_verify == r_fail, "R7",
          "done one cycle, status held", {done, busy, pass, fail_verify},
          {2'b00, r_pass, r_fail});
      exp_pass = 1'b1; stop = 0; total = 0;
      for (int w = 0; w < 8; w++) begin
         a = base + w;
         init  = ~preset_of(a);
         exp_d = data_w[w];
         exp_a = init;
         pl    = 0;
         if (w < n && stop == 0) begin
            active = ~data_w[w] & ben_of(be);
            maxn = 0;
            for (int b = 0; b < WB; b++)
               if (active[b]) begin
                  ne = init[b] ? need_of(a, b) : 0;
                  if (ne > maxn) maxn = ne;
               end
            pl = (maxn > MAXP) ? MAXP : maxn;
            if (maxn > MAXP) begin exp_pass = 1'b0; stop = 1; end
            for (int b = 0; b < WB; b++)
               if (active[b]) begin
                  ne = init[b] ? need_of(a, b) : 0;
                  if (ne <= pl) begin exp_d[b] = 1'b1; exp_a[b] = 1'b0; end
               end
         end
         rd_idx = IDXW'(w);
         #1;
         chk(rd_data == exp_d, "R4", $sformatf("mask word %0d", w), rd_data, exp_d);
         chk(arr_mem[a] == exp_a, "R2", $sformatf("array word %0d", a), arr_mem[a], exp_a);
         chk(arr_pc[a] == pl, "R1 R5", $sformatf("pulses at %0d", a),
             WB'(arr_pc[a]), WB'(pl));
         total += arr_pc[a];
      end
      chk(r_pass == exp_pass && r_fail == !exp_pass, exp_pass ? "R6" : "R5",
          "pass/fail_verify", {r_pass, r_fail}, {exp_pass, !exp_pass});
      chk(pmask_bad == 0, "R3", "pulse mask outside enables", WB'(pmask_bad), WB'(0));
      chk(order_bad == 0, "R1", "address order", WB'(order_bad), WB'(0));
      if (preset_all != 0)
         chk(total == 0, "R10", "no pulse on pre-programmed words", WB'(total), WB'(0));
      if (inject) begin
         repeat (3) @(negedge clk);
         chk(!busy, "R8", "start while busy not queued", WB'(busy), WB'(0));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R7 watchdog: act=running exp=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      #1;
      // R9: reset state
      chk(!busy && !done && !pass && !fail_verify, "R9", "status at reset",
          {busy, done, pass, fail_verify}, '0);
      for (int w = 0; w < 8; w++) begin
         rd_idx = IDXW'(w);
         #1;
         chk(rd_data == '1, "R9", $sformatf("data reg %0d at reset", w), rd_data, '1);
      end
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // single word, all enables
      salt = 3; span = 4; hard_on = 0; preset_all = 0;
      for (int w = 0; w < 8; w++) data_w[w] = rand_word();
      run_op(0, 2, 17'h1FFFF, 1'b0);

      // ECC enable cleared, two words
      salt = 11; span = 6;
      for (int w = 0; w < 8; w++) data_w[w] = rand_word();
      run_op(1, 5, 17'h0FFFF, 1'b0);

      // unreachable bit in second of four words: verify failure
      salt = 7; span = 3; hard_on = 1; hard_a = 9; hard_b = 40;
      for (int w = 0; w < 8; w++) data_w[w] = rand_word();
      data_w[1][40] = 1'b0;
      run_op(2, 8, 17'h1FFFF, 1'b0);
      hard_on = 0;

      // targets already programmed: verify first, no pulse
      salt = 5; span = 5; preset_all = 1;
      for (int w = 0; w < 8; w++) data_w[w] = rand_word();
      run_op(1, 0, 17'h1FFFF, 1'b0);
      preset_all = 0;

      // no byte enabled, eight words
      for (int w = 0; w < 8; w++) data_w[w] = rand_word();
      run_op(3, 20, 17'h00000, 1'b0);

      // start and write attempts while busy
      salt = 1; span = 6;
      for (int w = 0; w < 8; w++) data_w[w] = rand_word();
      run_op(2, 12, 17'h1FFFF, 1'b1);

      // constrained random
      for (int i = 0; i < 24; i++) begin
         int sz, bs;
         logic [BEW-1:0] be;
         sz   = int'($urandom % 4);
         bs   = int'($urandom % 25);
         be   = BEW'($urandom) | BEW'($urandom);
         salt = int'($urandom % 1000);
         span = 1 + int'($urandom % MAXP);
         hard_on = (($urandom % 3) == 0) ? 1 : 0;
         hard_a  = bs + int'($urandom % (1 << sz));
         hard_b  = int'($urandom % WB);
         for (int w = 0; w < 8; w++) data_w[w] = rand_word();
         run_op(sz, bs, be, (i % 5) == 0);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule